// File: doc/BRIEF.md
# UART Receive Error and Break Status

This block keeps the extended receive status of one UART channel. When the receiver reports that a frame has finished, the block looks at the sampled stop bit, the received data bits, the frame length and the current state of the receive-complete flag (RI). From these it raises three sticky error flags: a bad stop bit, a break (a character made entirely of zeros, stop bit included) and an overrun (a new character that lands while the previous one is still unread). Serial sampling and baud timing happen elsewhere. This block only sees the result of each frame.

A fourth bit, the status-interrupt enable, is loaded by software only. While it is set, any pending error flag raises the receive interrupt request alongside RI. The transmit interrupt has its own request output, so the receive and transmit sides can be served by different handlers. Software clears error flags through a single register write port. A write of 0 to a flag clears it, and a write of 1 leaves it unchanged.

Register bit layout: bit 0 = status-interrupt enable, bit 1 = overrun, bit 2 = break, bit 3 = framing error. All outputs are registered and come up zero after reset.

Top module: `uart_rx_status`

## Requirements
- R1: After a synchronous reset, `status` reads 4'b0000, and `rx_irq` and `tx_irq` are 0.
- R2: A cycle with `frame_done`=1 and `stop_bit`=0 sets `status[3]` (framing error) at the next clock edge.
- R3: A cycle with `frame_done`=1, `stop_bit`=0 and every data bit of the frame equal to 0 sets `status[2]` (break). If any counted data bit is 1, or the stop bit is 1, break is not set.
- R4: With `mode9`=0 the frame has 8 data bits and `rx_bits[8]` is ignored for break detection. With `mode9`=1 the frame has 9 data bits, and `rx_bits[8]` must also be 0 for break.
- R5: A cycle with `frame_done`=1 while `ri`=1 sets `status[1]` (overrun) at the next clock edge.
- R6: Error flags are sticky. Without a register write, a set flag stays set, and a flag is set only by its own detection condition.
- R7: A write (`reg_wr`=1) loads `status[0]` from `reg_wdata[0]`. For bits 3..1, a written 0 clears the flag and a written 1 leaves it unchanged. Without a write, `status[0]` never changes.
- R8: If a flag's hardware set condition and a software clear of that flag occur in the same cycle, the flag ends up set.
- R9: `rx_irq` equals, one clock later, `ri` OR (the enable bit AND any error flag), where the enable and flags are the values loaded at that same edge.
- R10: `tx_irq` equals `ti` delayed by one clock and is unaffected by any receive input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_done | input | 1 | One-cycle strobe: a received frame has completed |
| stop_bit | input | 1 | Sampled stop bit of the completed frame |
| rx_bits | input | 9 | Data bits of the completed frame (bit 8 used only in 9-bit mode) |
| mode9 | input | 1 | 1 = 9-bit data frames, 0 = 8-bit data frames |
| ri | input | 1 | Current receive-complete flag |
| ti | input | 1 | Current transmit-complete flag |
| reg_wr | input | 1 | Software write strobe for the status register |
| reg_wdata | input | 4 | Software write data |
| status | output | 4 | {framing, break, overrun, enable} |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The assertions assume that `frame_done` is a single-cycle strobe and that `stop_bit`, `rx_bits`, `mode9` and `ri` are valid in the cycle it is high. They also assume that `reg_wr` is the only way software reaches the register. The stimulus drives every input on the falling edge from a seeded random source. It keeps `reg_wr` rare so that flags live long enough to be seen as sticky, and it makes all-zero frames common so that break shows up often. Directed sequences cover set-against-clear collisions and both frame lengths.

// File: rtl/uart_rxst_pkg.sv
package uart_rxst_pkg;
  localparam int unsigned REG_W  = 4;
  localparam int unsigned NFLAGS = 3;
  // bit positions in the status register
  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_OVR  = 1;
  localparam int unsigned B_BRK  = 2;
  localparam int unsigned B_FRM  = 3;

  typedef struct packed {
    logic frm;
    logic brk;
    logic ovr;
  } rx_events_t;
endpackage

// File: rtl/rxst_detect.sv
module rxst_detect #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              frame_done,
  input  logic              stop_bit,
  input  logic [DATA_W:0]   rx_bits,
  input  logic              mode9,
  input  logic              ri,
  output uart_rxst_pkg::rx_events_t ev
);
  localparam int unsigned FULL_W = DATA_W + 1;

  logic low_zero;
  logic ext_zero;
  logic all_zero;

  assign low_zero = (rx_bits[DATA_W-1:0] == '0);
  // top data bit only counts for the long frame format
  assign ext_zero = mode9 ? ~rx_bits[FULL_W-1] : 1'b1;
  assign all_zero = low_zero & ext_zero;

  always_comb begin
    ev.frm = frame_done & ~stop_bit;
    ev.brk = frame_done & ~stop_bit & all_zero;
    ev.ovr = frame_done & ri;
  end
endmodule

// File: rtl/rxst_flags.sv
module rxst_flags
  import uart_rxst_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  rx_events_t       ev,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] stat_q,
  output logic [REG_W-1:0] stat_d
);
  logic [NFLAGS-1:0] set_vec;
  assign set_vec = {ev.frm, ev.brk, ev.ovr};

  assign stat_d[B_EN] = reg_wr ? reg_wdata[B_EN] : stat_q[B_EN];

  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    localparam int unsigned POS = g + 1;
    logic clr;
    assign clr = reg_wr & ~reg_wdata[POS];
    // hardware set has priority over software clear
    assign stat_d[POS] = set_vec[g] | (stat_q[POS] & ~clr);
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end

  AST_FRM_SET: assert property (@(posedge clk) disable iff (rst)
    ev.frm |=> stat_q[B_FRM]); // R2
  AST_BRK_WITH_FRM: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q[B_BRK]) |-> stat_q[B_FRM]); // R3
  AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
    ev.ovr |=> stat_q[B_OVR]); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> ((stat_q[3:1] & $past(stat_q[3:1])) == $past(stat_q[3:1]))); // R6
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> $stable(stat_q[B_EN])); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && ev.brk) |=> stat_q[B_BRK]); // R8
endmodule

// File: rtl/rxst_irq.sv
module rxst_irq
  import uart_rxst_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ri,
  input  logic             ti,
  input  logic [REG_W-1:0] stat_d,
  output logic             rx_irq,
  output logic             tx_irq
);
  logic err_any;
  assign err_any = |stat_d[REG_W-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_irq <= 1'b0;
      tx_irq <= 1'b0;
    end else begin
      rx_irq <= ri | (stat_d[B_EN] & err_any);
      tx_irq <= ti;
    end
  end

  AST_RI_IRQ: assert property (@(posedge clk) disable iff (rst)
    ri |=> rx_irq); // R9
  AST_TX_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    ti |=> tx_irq); // R10
  AST_TX_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ti |=> !tx_irq); // R10
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rxst_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_done,
  input  logic              stop_bit,
  input  logic [DATA_W:0]   rx_bits,
  input  logic              mode9,
  input  logic              ri,
  input  logic              ti,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  status,
  output logic              rx_irq,
  output logic              tx_irq
);
  rx_events_t       ev;
  logic [REG_W-1:0] stat_d;

  rxst_detect #(.DATA_W(DATA_W)) i_detect (
    .frame_done(frame_done),
    .stop_bit  (stop_bit),
    .rx_bits   (rx_bits),
    .mode9     (mode9),
    .ri        (ri),
    .ev        (ev)
  );

  rxst_flags i_flags (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .stat_q   (status),
    .stat_d   (stat_d)
  );

  rxst_irq i_irq (
    .clk   (clk),
    .rst   (rst),
    .ri    (ri),
    .ti    (ti),
    .stat_d(stat_d),
    .rx_irq(rx_irq),
    .tx_irq(tx_irq)
  );

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (status == '0 && !rx_irq && !tx_irq)); // R1
endmodule

// File: tb/test_uart_rx_status.sv
module test_uart_rx_status;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_done = 0, stop_bit = 1, mode9 = 0, ri = 0, ti = 0, reg_wr = 0;
  logic [8:0] rx_bits = '0;
  logic [3:0] reg_wdata = '0;
  logic [3:0] status;
  logic rx_irq, tx_irq;

  int checks = 0;
  int fails = 0;
  logic [3:0] m_stat = '0;
  logic m_rx = 0, m_tx = 0;

  always #2.5 clk = ~clk;

  uart_rx_status i_uart_rx_status (
    .clk(clk), .rst(rst), .frame_done(frame_done), .stop_bit(stop_bit),
    .rx_bits(rx_bits), .mode9(mode9), .ri(ri), .ti(ti), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .status(status), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  function automatic logic [3:0] model_next(logic [3:0] s);
    logic zero, fe, br, oe;
    logic [3:0] n;
    zero = (rx_bits[7:0] == 8'h00) && (!mode9 || !rx_bits[8]);
    fe = frame_done && !stop_bit;
    br = fe && zero;
    oe = frame_done && ri;
    n[0] = reg_wr ? reg_wdata[0] : s[0];
    n[1] = oe | (s[1] & ~(reg_wr & ~reg_wdata[1]));
    n[2] = br | (s[2] & ~(reg_wr & ~reg_wdata[2]));
    n[3] = fe | (s[3] & ~(reg_wr & ~reg_wdata[3]));
    return n;
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // apply current inputs across one edge, update model, compare
  task automatic step(string tag);
    logic [3:0] n;
    n = model_next(m_stat);
    @(posedge clk);
    if (rst) begin
      m_stat = '0; m_rx = 0; m_tx = 0;
    end else begin
      m_rx = ri | (n[0] & |n[3:1]);
      m_tx = ti;
      m_stat = n;
    end
    @(negedge clk);
    check(tag, status, m_stat);
    check({tag, " irq"}, {2'b00, rx_irq, tx_irq}, {2'b00, m_rx, m_tx});
    frame_done = 0; reg_wr = 0;
  endtask

  task automatic frame(logic sb, logic [8:0] bits, logic m9, logic r, string tag);
    frame_done = 1; stop_bit = sb; rx_bits = bits; mode9 = m9; ri = r;
    step(tag);
    ri = 0;
  endtask

  task automatic wr(logic [3:0] d, string tag);
    reg_wr = 1; reg_wdata = d;
    step(tag);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    step("R1 reset");
    step("R1 reset");
    rst = 0;
    step("R1 idle");
    check("R1 status zero", status, 4'b0000);

    frame(1'b0, 9'h055, 1'b0, 1'b0, "R2 framing");
    check("R2 fe bit", {3'b0, status[3]}, 4'b0001);
    check("R3 no break nonzero", {3'b0, status[2]}, 4'b0000);
    wr(4'b0000, "R7 clear all");
    frame(1'b0, 9'h000, 1'b0, 1'b0, "R3 break");
    check("R3 break bit", {3'b0, status[2]}, 4'b0001);
    wr(4'b0000, "R7 clear");
    frame(1'b1, 9'h000, 1'b0, 1'b0, "R3 stop high no break");
    check("R3 stop high", status, 4'b0000);
    frame(1'b0, 9'h100, 1'b0, 1'b0, "R4 mode8 ignores bit8");
    check("R4 mode8 break", {3'b0, status[2]}, 4'b0001);
    wr(4'b0000, "R7 clear");
    frame(1'b0, 9'h100, 1'b1, 1'b0, "R4 mode9 bit8 one");
    check("R4 mode9 no break", {3'b0, status[2]}, 4'b0000);
    wr(4'b0000, "R7 clear");
    frame(1'b1, 9'h0A0, 1'b0, 1'b1, "R5 overrun");
    check("R5 oe bit", status, 4'b0010);
    step("R6 hold"); step("R6 hold");
    check("R6 sticky", status, 4'b0010);
    wr(4'b1111, "R7 write ones keep");
    check("R7 enable loaded", status, 4'b0011);
    check("R9 irq with enable", {3'b0, rx_irq}, 4'b0001);
    wr(4'b1101, "R7 clear oe only");
    check("R7 oe cleared", status, 4'b0001);
    check("R9 no irq", {3'b0, rx_irq}, 4'b0000);
    reg_wr = 1; reg_wdata = 4'b0001;
    frame(1'b0, 9'h000, 1'b0, 1'b1, "R8 set wins");
    check("R8 all set", status, 4'b1111);
    ti = 1; step("R10 tx");
    check("R10 tx irq", {3'b0, tx_irq}, 4'b0001);
    ti = 0; wr(4'b0000, "R7 clear");
    ri = 1; step("R9 ri");
    check("R9 ri irq", {3'b0, rx_irq}, 4'b0001);
    ri = 0;

    for (int i = 0; i < 4000; i++) begin
      frame_done = ($urandom % 4) == 0;
      stop_bit   = ($urandom % 3) != 0;
      rx_bits    = (($urandom % 2) == 0) ? 9'h000 : 9'($urandom);
      mode9      = $urandom % 2;
      ri         = $urandom % 2;
      ti         = $urandom % 2;
      reg_wr     = ($urandom % 12) == 0;
      reg_wdata  = 4'($urandom);
      if (($urandom % 500) == 0) rst = 1;
      step("R6 random");
      rst = 0;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule